// File: doc/BRIEF.md
# Discovery Event Register with Change Filtering

This block collects the outcome of detection and classification cycles for the channels of a power-sourcing controller. Each channel reports the end of a detection cycle with a one-cycle `det_done` pulse and a result code, and the end of a classification cycle with a `cls_done` pulse and a class code. The block keeps the last result for every channel and kind. It sets an event bit either for every completed cycle or only for a cycle whose result differs from the stored one. A separate change-filter enable controls each kind.

Software reads the event byte through a small register port and clears bits by writing ones. An active-low interrupt output goes low when the master interrupt enable is set and an unmasked summary (any detection event, any class event) is pending. The master enable gates only the pin. Event capture goes on while it is clear.

Each channel and kind has a history tracker, a two-state machine. `HIST_EMPTY` means no result is known. `HIST_VALID` means a previous code is held. The transition `capture` (`HIST_EMPTY` to `HIST_VALID`) takes place on the first completed cycle. The transition `refresh` (`HIST_VALID` to `HIST_VALID`) takes place on each later completed cycle. Reset returns every tracker to `HIST_EMPTY`.

Top module: `disc_event_reg`

## Requirements
- R1: After reset, the registers hold these values. The event byte is 0 and the interrupt output is high. The control register (address 1) reads 0x01: bit 0 is the master interrupt enable (reset 1), bit 1 is the detection change filter (reset 0) and bit 2 is the class change filter (reset 0). The mask register (address 2) reads 0x00: bit 0 enables the detection summary and bit 1 enables the class summary. Unused read bits and unused addresses read 0.
- R2: With the detection filter at 0, every `det_done[i]` pulse sets event bit i (the lower nibble, channel 0 in bit 0) at the next clock edge.
- R3: With the detection filter at 1, a `det_done[i]` pulse sets event bit i only when its code differs from the stored detection code of channel i.
- R4: The class filter applies the same rule to `cls_done`/`cls_code`, and class events occupy the upper nibble (channel i in bit 4+i).
- R5: Reset empties every history, so the first completed cycle after reset always counts as a change. Every completed cycle stores its code, whether or not it set an event bit.
- R6: Writing to address 0 clears the event bits written as 1 and leaves the bits written as 0 unchanged. Event bits do not change without a done pulse or such a write.
- R7: If an event and a clear of the same bit occur in the same cycle, the bit ends up set.
- R8: `irq_n` is low exactly when the master enable is 1 and at least one pending summary has its mask bit set.
- R9: With the master enable at 0, `irq_n` stays high, and event bits are still captured and kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_done | input | NUM_CH | Detection-complete pulse per channel |
| det_code | input | NUM_CH*CODE_W | Detection result per channel, channel 0 in the low field |
| cls_done | input | NUM_CH | Classification-complete pulse per channel |
| cls_code | input | NUM_CH*CODE_W | Class result per channel, channel 0 in the low field |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address (0 events, 1 control, 2 mask) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The bench uses the defaults NUM_CH=4, CODE_W=4 and DATA_W=8. With these values the two nibbles fill the event byte exactly, so every bit position, including the top class bit, can be cleared and observed. Four-bit codes leave enough distinct values to put matching and differing results side by side in one pulse. The stimulus table therefore sets and filters bits on different channels at once, under all four combinations of the two filters.

// File: rtl/disc_evt_pkg.sv
package disc_evt_pkg;

    typedef enum logic {
        HIST_EMPTY = 1'b0,
        HIST_VALID = 1'b1
    } hist_state_e;

    localparam int REG_ADDR_W = 2;
    localparam logic [REG_ADDR_W-1:0] ADDR_EVT  = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_MASK = 2'd2;

    localparam int CTRL_INT_EN  = 0;
    localparam int CTRL_DET_CHG = 1;
    localparam int CTRL_CLS_CHG = 2;

endpackage

// File: rtl/disc_hist.sv
module disc_hist
    import disc_evt_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [CODE_W-1:0] code,
    input  logic              chg_en,
    output logic              report
);

    hist_state_e       state_q, state_d;
    logic [CODE_W-1:0] prev_q;

    // State register: the stored code follows every completed cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HIST_EMPTY;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            if (done) begin
                prev_q <= code;
            end
        end
    end

    // Next state and event decision
    always_comb begin
        state_d = state_q;
        report  = 1'b0;
        unique case (state_q)
            HIST_EMPTY: begin
                if (done) begin
                    state_d = HIST_VALID;   // capture
                    report  = 1'b1;
                end
            end
            HIST_VALID: begin
                if (done) begin
                    state_d = HIST_VALID;   // refresh
                    report  = !chg_en || (code != prev_q);
                end
            end
            default: state_d = HIST_EMPTY;
        endcase
    end

endmodule

// File: rtl/disc_evt_bank.sv
module disc_evt_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] evt
);

    logic [W-1:0] evt_q;

    // A new event outweighs a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= (evt_q & ~clr) | set;
        end
    end

    assign evt = evt_q;

endmodule

// File: rtl/disc_irq.sv
module disc_irq #(
    parameter int NUM_CH = 4
) (
    input  logic [2*NUM_CH-1:0] evt,
    input  logic                int_en,
    input  logic [1:0]          mask,
    output logic                irq_n
);

    logic det_sum, cls_sum;

    assign det_sum = |evt[NUM_CH-1:0];
    assign cls_sum = |evt[2*NUM_CH-1:NUM_CH];

    always_comb begin
        irq_n = !(int_en && ((det_sum && mask[0]) || (cls_sum && mask[1])));
    end

endmodule

// File: rtl/disc_event_reg.sv
module disc_event_reg
    import disc_evt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = REG_ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        det_done,
    input  logic [NUM_CH*CODE_W-1:0] det_code,
    input  logic [NUM_CH-1:0]        cls_done,
    input  logic [NUM_CH*CODE_W-1:0] cls_code,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic                     irq_n
);

    localparam int EVT_W = 2 * NUM_CH;

    logic              int_en_q, det_chg_q, cls_chg_q;
    logic [1:0]        mask_q;
    logic [NUM_CH-1:0] det_rep, cls_rep;
    logic [EVT_W-1:0]  evt_set, evt_clr, evt_q;
    logic              wr_evt, wr_ctrl, wr_mask;

    assign wr_evt  = wr_en && (addr == ADDR_W'(ADDR_EVT));
    assign wr_ctrl = wr_en && (addr == ADDR_W'(ADDR_CTRL));
    assign wr_mask = wr_en && (addr == ADDR_W'(ADDR_MASK));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_en_q  <= 1'b1;
            det_chg_q <= 1'b0;
            cls_chg_q <= 1'b0;
            mask_q    <= 2'b00;
        end else begin
            if (wr_ctrl) begin
                int_en_q  <= wdata[CTRL_INT_EN];
                det_chg_q <= wdata[CTRL_DET_CHG];
                cls_chg_q <= wdata[CTRL_CLS_CHG];
            end
            if (wr_mask) begin
                mask_q <= wdata[1:0];
            end
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        disc_hist #(.CODE_W(CODE_W)) u_det_hist (
            .clk    (clk),
            .rst_n  (rst_n),
            .done   (det_done[i]),
            .code   (det_code[i*CODE_W +: CODE_W]),
            .chg_en (det_chg_q),
            .report (det_rep[i])
        );
        disc_hist #(.CODE_W(CODE_W)) u_cls_hist (
            .clk    (clk),
            .rst_n  (rst_n),
            .done   (cls_done[i]),
            .code   (cls_code[i*CODE_W +: CODE_W]),
            .chg_en (cls_chg_q),
            .report (cls_rep[i])
        );
    end

    assign evt_set = {cls_rep, det_rep};
    assign evt_clr = wr_evt ? wdata[EVT_W-1:0] : '0;

    disc_evt_bank #(.W(EVT_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (evt_set),
        .clr   (evt_clr),
        .evt   (evt_q)
    );

    disc_irq #(.NUM_CH(NUM_CH)) u_irq (
        .evt    (evt_q),
        .int_en (int_en_q),
        .mask   (mask_q),
        .irq_n  (irq_n)
    );

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_EVT)) begin
            rdata[EVT_W-1:0] = evt_q;
        end else if (addr == ADDR_W'(ADDR_CTRL)) begin
            rdata[CTRL_INT_EN]  = int_en_q;
            rdata[CTRL_DET_CHG] = det_chg_q;
            rdata[CTRL_CLS_CHG] = cls_chg_q;
        end else if (addr == ADDR_W'(ADDR_MASK)) begin
            rdata[1:0] = mask_q;
        end
    end

endmodule

// File: rtl/disc_event_chk.sv
module disc_event_chk #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_CH-1:0]   det_done,
    input logic [NUM_CH-1:0]   cls_done,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wdata,
    input logic [2*NUM_CH-1:0] evt,
    input logic                int_en,
    input logic                det_chg,
    input logic                cls_chg,
    input logic                irq_n
);

    // R9
    int_off_pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> irq_n);

    // R8
    pin_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (int_en && (evt != '0)));

    // R6
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && det_done == '0 && cls_done == '0) |=> $stable(evt));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R2
        det_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (det_done[i] && !det_chg) |=> evt[i]);
        // R4
        cls_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cls_done[i] && !cls_chg) |=> evt[NUM_CH+i]);
        // R6
        det_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == '0 && wdata[i] && !det_done[i]) |=> !evt[i]);
    end

endmodule

bind disc_event_reg disc_event_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .det_done (det_done),
    .cls_done (cls_done),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .evt      (evt_q),
    .int_en   (int_en_q),
    .det_chg  (det_chg_q),
    .cls_chg  (cls_chg_q),
    .irq_n    (irq_n)
);

// File: tb/disc_event_reg_test.sv
module disc_event_reg_test;

    localparam int NUM_CH = 4;
    localparam int CODE_W = 4;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NUM_CH-1:0]        det_done = '0;
    logic [NUM_CH*CODE_W-1:0] det_code = '0;
    logic [NUM_CH-1:0]        cls_done = '0;
    logic [NUM_CH*CODE_W-1:0] cls_code = '0;
    logic                     wr_en = 1'b0;
    logic [ADDR_W-1:0]        addr = '0;
    logic [DATA_W-1:0]        wdata = '0;
    logic [DATA_W-1:0]        rdata;
    logic                     irq_n;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    disc_event_reg #(
        .NUM_CH(NUM_CH), .CODE_W(CODE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .det_done(det_done), .det_code(det_code),
        .cls_done(cls_done), .cls_code(cls_code), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
    );

    // fields: filters{cls,det} | det_done | det codes | cls_done | cls codes | expected events
    localparam logic [49:0] VEC [6] = '{
        {2'b11, 4'b1111, 16'h1111, 4'b1111, 16'h2222, 8'hFF},
        {2'b11, 4'b1111, 16'h1111, 4'b1111, 16'h2222, 8'h00},
        {2'b11, 4'b0101, 16'h1311, 4'b1010, 16'h5222, 8'h84},
        {2'b00, 4'b0011, 16'h1311, 4'b0001, 16'h5222, 8'h13},
        {2'b01, 4'b1000, 16'h7311, 4'b0100, 16'h5222, 8'h48},
        {2'b10, 4'b1000, 16'h7311, 4'b0100, 16'h5222, 8'h08}
    };
    localparam string VREQ [6] = '{"R5", "R3", "R3 R4", "R2 R4", "R3 R4", "R2 R4"};

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic reg_rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        addr = a;
        #1;
        d = rdata;
        addr = '0;
    endtask

    task automatic pulse(input logic [3:0] dd, input logic [15:0] dc,
                         input logic [3:0] cd, input logic [15:0] cc);
        @(negedge clk);
        det_done = dd; det_code = dc; cls_done = cd; cls_code = cc;
        @(negedge clk);
        det_done = '0; cls_done = '0;
    endtask

    initial begin
        #1_000_000;
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] rd;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_rd(2'd0, rd); chk("R1 events", rd, 8'h00);
        reg_rd(2'd1, rd); chk("R1 control", rd, 8'h01);
        reg_rd(2'd2, rd); chk("R1 mask", rd, 8'h00);
        reg_rd(2'd3, rd); chk("R1 unused", rd, 8'h00);
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);

        for (int v = 0; v < 6; v++) begin
            reg_wr(2'd1, {5'd0, VEC[v][49], VEC[v][48], 1'b1});
            pulse(VEC[v][47:44], VEC[v][43:28], VEC[v][27:24], VEC[v][23:8]);
            reg_rd(2'd0, rd); chk(VREQ[v], rd, VEC[v][7:0]);
            reg_wr(2'd0, 8'hFF);
            reg_rd(2'd0, rd); chk("R6 clear all", rd, 8'h00);
        end

        // R8 masked detection summary drives pin
        reg_wr(2'd2, 8'h01);
        reg_wr(2'd1, 8'h01);
        pulse(4'b0001, 16'h7311, 4'b0000, 16'h5222);
        chk("R8 irq low", {7'd0, irq_n}, 8'h00);
        // R9 master enable off
        reg_wr(2'd1, 8'h00);
        chk("R9 irq high", {7'd0, irq_n}, 8'h01);
        pulse(4'b0000, 16'h7311, 4'b0010, 16'h5222);
        reg_rd(2'd0, rd); chk("R9 capture", rd, 8'h21);
        chk("R9 irq still high", {7'd0, irq_n}, 8'h01);
        reg_wr(2'd2, 8'h02);
        reg_wr(2'd1, 8'h01);
        chk("R8 class summary", {7'd0, irq_n}, 8'h00);
        reg_wr(2'd2, 8'h00);
        chk("R8 all masked", {7'd0, irq_n}, 8'h01);

        // R7 set wins over clear of the same bit
        @(negedge clk);
        det_done = 4'b0010; det_code = 16'h7311;
        wr_en = 1'b1; addr = 2'd0; wdata = 8'h02;
        @(negedge clk);
        det_done = '0; wr_en = 1'b0; wdata = '0;
        reg_rd(2'd0, rd); chk("R7 set wins", rd, 8'h23);
        // R6 partial clear
        reg_wr(2'd0, 8'h01);
        reg_rd(2'd0, rd); chk("R6 partial clear", rd, 8'h22);
        reg_wr(2'd0, 8'hFF);

        // R5 history emptied by reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        reg_rd(2'd1, rd); chk("R1 control after reset", rd, 8'h01);
        reg_wr(2'd1, 8'h03);
        pulse(4'b0001, 16'h7311, 4'b0000, 16'h0000);
        reg_rd(2'd0, rd); chk("R5 first after reset", rd, 8'h01);
        reg_wr(2'd0, 8'hFF);
        pulse(4'b0001, 16'h7311, 4'b0000, 16'h0000);
        reg_rd(2'd0, rd); chk("R3 repeat filtered", rd, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule